// File: doc/BRIEF.md
# Tap-Selectable Twisted-Ring Divider

This block is a twisted-ring (Johnson) counter whose length is chosen while the chip runs. Four D registers form a shift chain. The first register takes the inverse of the last register that is in use, so the ring fills with ones starting at stage 0 and then drains with zeros. Each stage, and the divided output, then produce a square wave at the clock rate divided by twice the active length. A 3-bit tap selector picks one of five positions. Positions 1 to 4 use stages 0 to k-1 and divide by 2k. Position 5 passes the input clock straight to the divided output.

A change of selection never carries a partial pattern into the new length. On the clock edge where the selector differs from the registered selection, the ring is cleared to all zeros. Counting with the new length starts on the following edge. Any pattern that is neither a fill nor a drain form is also cleared on the next edge.

In position 3 the block drives a three-phase bundle. It consists of stage 0, stage 2 and the inverse of stage 1. These are three square waves with a period of six clocks, each lagging the previous one by two clocks (120 degrees).

Top module: `jtap_divider`

## Requirements
- R1: While `rst_i` is high, every clock edge sets `stage_o` to 0 and latches the current selector, so no clear follows. With a selector of 1 to 4, `div_o` is low during reset. The first edge after reset with a steady selector gives `stage_o` = 1.
- R2: In selector position k (1 to 4), the stage bits k and above always read 0.
- R3: With the selector steady at k (1 to 4), each clock edge shifts `stage_o` up by one bit. Bit 0 takes the inverse of bit k-1, and bits at k and above stay 0.
- R4: In position k (1 to 4), `div_o` equals stage bit k-1. It is high for k clocks and low for k clocks in every 2k-clock period.
- R5: In position 4, the states starting from all zeros run 0x1, 0x3, 0x7, 0xF, 0xE, 0xC, 0x8, 0x0: eight distinct states.
- R6: On the edge where `tap_sel_i` differs from the previously registered value, `stage_o` becomes 0. Counting with the new length starts on the next edge.
- R7: In position 5, `stage_o` stays 0 and `div_o` follows `clk_i` (high while the clock is high, low while it is low).
- R8: Selector codes 0, 6 and 7 hold `stage_o` at 0 and `div_o` low.
- R9: In position 3, `phase_o` = {~stage1, stage2, stage0}. Each bit is high for 3 of every 6 clocks. Bit 1 equals bit 0 from two edges earlier, and bit 2 equals bit 0 from four edges earlier. In other positions `phase_o` is 0.
- R10: `stage_o` only ever holds a fill form (ones from bit 0 upward) or a drain form (ones from the top active bit downward) within the active stages. Any other pattern is forced to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; also the pass-through source in position 5 |
| rst_i | input | 1 | Synchronous active-high reset |
| tap_sel_i | input | 3 | Tap position: 1-4 ring length, 5 pass-through, others idle |
| stage_o | output | 4 | Current ring register contents, stage 0 in bit 0 |
| div_o | output | 1 | Divided output |
| phase_o | output | 3 | Three-phase bundle in position 3, otherwise zero |

## Verification
On every cycle, the in-RTL assertions check the following:
- the ring moves on every active edge;
- inactive stages stay at zero;
- the register contents keep a legal fill or drain form;
- a selector change empties the ring;
- the idle and pass-through positions keep the ring empty;
- in position 3, the phase bundle keeps its two-edge lag between bits.

Only the directed scenarios can show the exact state sequences and the duty cycle of `div_o` for each length. They also cover the clock-following behaviour in position 5, which needs sampling in both clock phases, and the restart after a change in the middle of a count or a reset.

// File: rtl/jtap_pkg.sv
`timescale 1ns/1ps
package jtap_pkg;

    localparam int unsigned RING_LEN  = 4;
    localparam int unsigned TAP_W     = $clog2(RING_LEN + 2);
    localparam int unsigned PASS_POS  = RING_LEN + 1;
    localparam int unsigned PHASE_POS = 3;
    localparam int unsigned PHASE_W   = 3;

    typedef logic [RING_LEN-1:0] ring_t;
    typedef logic [TAP_W-1:0]    tap_t;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_RING = 2'd1,
        MODE_PASS = 2'd2
    } tap_mode_e;

    typedef struct packed {
        tap_mode_e mode;
        ring_t     mask;   // active stages
        ring_t     top;    // one-hot: last active stage
    } tap_cfg_t;

    function automatic tap_cfg_t decode_tap(input tap_t sel);
        tap_cfg_t cfg;
        cfg.mode = MODE_IDLE;
        cfg.mask = '0;
        cfg.top  = '0;
        if (int'(sel) == int'(PASS_POS)) begin
            cfg.mode = MODE_PASS;
        end else if (int'(sel) >= 1 && int'(sel) <= int'(RING_LEN)) begin
            cfg.mode = MODE_RING;
            for (int i = 0; i < int'(RING_LEN); i++) begin
                cfg.mask[i] = (i < int'(sel));
                cfg.top[i]  = (i == int'(sel) - 1);
            end
        end
        return cfg;
    endfunction

    // Fill form: ones contiguous from bit 0. Drain form: zeros contiguous
    // from bit 0 inside the active mask.
    function automatic logic is_legal(input ring_t q, input ring_t mask);
        ring_t holes;
        logic  fill_ok;
        logic  drain_ok;
        holes    = ~q & mask;
        fill_ok  = ((q & ring_t'(q + 1'b1)) == '0);
        drain_ok = ((holes & ring_t'(holes + 1'b1)) == '0);
        return ((q & ~mask) == '0) && (fill_ok || drain_ok);
    endfunction

endpackage

// File: rtl/jtap_sel_track.sv
`timescale 1ns/1ps
module jtap_sel_track
    import jtap_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  tap_t tap_i,
    output tap_t tap_q_o,
    output logic clear_o
);

    tap_t tap_q;

    always_ff @(posedge clk_i) begin
        tap_q <= tap_i;
    end

    assign tap_q_o = tap_q;
    assign clear_o = !rst_i && (tap_i != tap_q);

    assert_track_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        clear_o |=> (tap_q_o == $past(tap_i)));

endmodule

// File: rtl/jtap_ring.sv
`timescale 1ns/1ps
module jtap_ring
    import jtap_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     clear_i,
    input  tap_cfg_t cfg_i,
    output ring_t    q_o
);

    ring_t q_r;
    ring_t d_shift;
    logic  fb;
    logic  legal;

    assign fb    = |(q_r & cfg_i.top);
    assign legal = is_legal(q_r, cfg_i.mask);

    genvar gi;
    generate
        for (gi = 0; gi < int'(RING_LEN); gi++) begin : g_stage
            if (gi == 0) begin : g_head
                assign d_shift[gi] = ~fb & cfg_i.mask[gi];
            end else begin : g_body
                assign d_shift[gi] = q_r[gi-1] & cfg_i.mask[gi];
            end
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i || !legal) begin
            q_r <= '0;
        end else if (cfg_i.mode == MODE_RING) begin
            q_r <= d_shift;
        end else begin
            q_r <= '0;
        end
    end

    assign q_o = q_r;

    assert_moves_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_i.mode == MODE_RING && !clear_i) |=> (q_r != $past(q_r)));

    assert_upper_zero_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        ((q_r & ~cfg_i.mask) == '0));

    assert_legal_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        legal);

endmodule

// File: rtl/jtap_out_sel.sv
`timescale 1ns/1ps
module jtap_out_sel
    import jtap_pkg::*;
(
    input  logic               clk_i,
    input  tap_t               tap_q_i,
    input  tap_cfg_t           cfg_i,
    input  ring_t              q_i,
    output logic               div_o,
    output logic [PHASE_W-1:0] phase_o
);

    always_comb begin
        unique case (cfg_i.mode)
            MODE_PASS: div_o = clk_i;
            MODE_RING: div_o = |(q_i & cfg_i.top);
            default:   div_o = 1'b0;
        endcase
    end

    generate
        if (RING_LEN >= PHASE_POS) begin : g_phase
            always_comb begin
                if (int'(tap_q_i) == int'(PHASE_POS)) begin
                    phase_o = {~q_i[1], q_i[2], q_i[0]};
                end else begin
                    phase_o = '0;
                end
            end
        end else begin : g_no_phase
            assign phase_o = '0;
        end
    endgenerate

endmodule

// File: rtl/jtap_divider.sv
`timescale 1ns/1ps
module jtap_divider
    import jtap_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic [TAP_W-1:0]      tap_sel_i,
    output logic [RING_LEN-1:0]   stage_o,
    output logic                  div_o,
    output logic [PHASE_W-1:0]    phase_o
);

    tap_t     tap_q;
    logic     clear;
    tap_cfg_t cfg;
    ring_t    ring_q;

    jtap_sel_track i_track (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tap_i   (tap_sel_i),
        .tap_q_o (tap_q),
        .clear_o (clear)
    );

    assign cfg = decode_tap(tap_q);

    jtap_ring i_ring (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (clear),
        .cfg_i   (cfg),
        .q_o     (ring_q)
    );

    jtap_out_sel i_out (
        .clk_i   (clk_i),
        .tap_q_i (tap_q),
        .cfg_i   (cfg),
        .q_i     (ring_q),
        .div_o   (div_o),
        .phase_o (phase_o)
    );

    assign stage_o = ring_q;

    // Edges elapsed since the last clear, saturating; bounds $past below.
    logic [2:0] run_q;
    always_ff @(posedge clk_i) begin
        if (rst_i || clear) begin
            run_q <= '0;
        end else if (run_q != 3'd7) begin
            run_q <= run_q + 3'd1;
        end
    end

    assert_clear_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (tap_sel_i != tap_q) |=> (stage_o == '0));

    assert_pass_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg.mode == MODE_PASS) |-> (stage_o == '0));

    assert_idle_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg.mode == MODE_IDLE) |-> (stage_o == '0 && !div_o));

    assert_phase_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q >= 3'd4 && int'(tap_q) == int'(PHASE_POS) && !clear)
        |-> (phase_o[1] == $past(phase_o[0], 2) &&
             phase_o[2] == $past(phase_o[0], 4)));

endmodule

// File: tb/test_jtap_divider.sv
`timescale 1ns/1ps
module test_jtap_divider;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] tap;
    logic [3:0] stage;
    logic       div;
    logic [2:0] phase;
    int         n_chk  = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    jtap_divider i_jtap_divider (
        .clk_i     (clk),
        .rst_i     (rst),
        .tap_sel_i (tap),
        .stage_o   (stage),
        .div_o     (div),
        .phase_o   (phase)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    function automatic int nxt(input int e, input int k);
        int fb;
        fb = (e >> (k - 1)) & 1;
        return ((e << 1) | (fb ^ 1)) & ((1 << k) - 1);
    endfunction

    function automatic bit legal_form(input int q, input int k);
        int m;
        int h;
        m = (1 << k) - 1;
        h = ~q & m;
        if ((q & ~m) != 0) return 1'b0;
        return ((q & (q + 1)) == 0) || ((h & (h + 1)) == 0);
    endfunction

    task automatic set_tap(input int k);
        tap = 3'(k);
        cyc();
        check(stage == 4'h0, "R6 clear on select change", int'(stage), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tap = 3'd4;
        cyc(); cyc(); cyc();
        check(stage == 4'h0, "R1 stage in reset", int'(stage), 0);
        check(div == 1'b0, "R1 div in reset", int'(div), 0);
        rst = 1'b0;
        cyc();
        check(stage == 4'h1, "R1 first step after reset", int'(stage), 1);
    endtask

    task automatic t_length(input int k);
        int e;
        int highs;
        set_tap(k);
        e = 0;
        highs = 0;
        for (int i = 0; i < 4 * k; i++) begin
            cyc();
            e = nxt(e, k);
            check(int'(stage) == e, "R3 shift step", int'(stage), e);
            check((int'(stage) >> k) == 0, "R2 upper stages zero", int'(stage), e);
            check(int'(div) == ((e >> (k - 1)) & 1), "R4 div follows last stage", int'(div), (e >> (k - 1)) & 1);
            check(legal_form(int'(stage), k), "R10 legal form", int'(stage), e);
            highs += int'(div);
        end
        check(highs == 2 * k, "R4 duty over two periods", highs, 2 * k);
    endtask

    task automatic t_seq4();
        int seq [8] = '{1, 3, 7, 15, 14, 12, 8, 0};
        set_tap(4);
        for (int i = 0; i < 8; i++) begin
            cyc();
            check(int'(stage) == seq[i], "R5 eight-state order", int'(stage), seq[i]);
        end
    endtask

    task automatic t_phase();
        int p0 [18];
        int p1 [18];
        int p2 [18];
        int hi;
        set_tap(3);
        for (int t = 0; t < 18; t++) begin
            p0[t] = int'(phase[0]);
            p1[t] = int'(phase[1]);
            p2[t] = int'(phase[2]);
            cyc();
        end
        for (int t = 4; t < 18; t++) begin
            check(p1[t] == p0[t-2], "R9 phase1 lags two", p1[t], p0[t-2]);
            check(p2[t] == p0[t-4], "R9 phase2 lags four", p2[t], p0[t-4]);
        end
        hi = 0;
        for (int t = 6; t < 12; t++) hi += p0[t];
        check(hi == 3, "R9 half duty", hi, 3);
        tap = 3'd1;
        cyc();
        check(phase == 3'b000, "R9 phase zero off position 3", int'(phase), 0);
    endtask

    task automatic t_pass();
        set_tap(5);
        for (int i = 0; i < 4; i++) begin
            check(div == 1'b1, "R7 div high with clock", int'(div), 1);
            check(stage == 4'h0, "R7 ring empty", int'(stage), 0);
            @(negedge clk);
            #1;
            check(div == 1'b0, "R7 div low with clock", int'(div), 0);
            cyc();
        end
    endtask

    task automatic t_idle(input int v);
        set_tap(v);
        for (int i = 0; i < 5; i++) begin
            cyc();
            check(stage == 4'h0 && div == 1'b0, "R8 idle code holds zero", int'({div, stage}), 0);
        end
    endtask

    task automatic t_midchange();
        int exp2 [4] = '{1, 3, 2, 0};
        set_tap(4);
        for (int i = 0; i < 5; i++) cyc();
        check(stage == 4'hE, "R3 mid-count state", int'(stage), 14);
        tap = 3'd2;
        cyc();
        check(stage == 4'h0, "R6 clear mid-count", int'(stage), 0);
        for (int i = 0; i < 4; i++) begin
            cyc();
            check(int'(stage) == exp2[i], "R3 new length after change", int'(stage), exp2[i]);
        end
    endtask

    task automatic t_midreset();
        set_tap(1);
        cyc();
        cyc();
        rst = 1'b1;
        cyc();
        check(stage == 4'h0, "R1 reset mid-run", int'(stage), 0);
        rst = 1'b0;
        cyc();
        check(stage == 4'h1, "R1 restart after reset", int'(stage), 1);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1;
        tap = 3'd4;
        t_reset();
        t_length(1);
        t_length(2);
        t_length(3);
        t_length(4);
        t_idle(0);
        t_seq4();
        t_phase();
        t_pass();
        t_idle(7);
        t_idle(6);
        t_midchange();
        t_midreset();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule